// File: doc/BRIEF.md
# Interrupt Mask and Priority Register Bank

This block holds a small bank of interrupt control registers on a simple register bus. Each register answers at a primary (set) address and, optionally, at a secondary (clear) address. Which address a write hits selects how the write is applied. A write to the primary address of a register that also has a clear address ORs the data into the stored value. A write to the clear address removes the written bits. A write to a register that has only a primary address replaces the stored value.

Every register is divided into equal fields. Mask registers use one-bit fields and priority registers use wider ones. Each field is tied to an interrupt source number. After each accepted write the block compares every field with its previous contents. For each field that changed it sends an event to the interrupt fabric. The event carries the source number and says whether the field became nonzero (enable) or zero (disable). Events leave one per cycle, and the block holds off further writes until the last event has gone out.

Top module: `irq_mask_bank`

## Requirements
- R1: Only address bits 28:0 are used for matching. A bus address whose bits 28:0 equal those of a configured address selects that register, whatever bits 31:29 hold.
- R2: For a register that has both addresses, a write to the primary address stores old OR data.
- R3: For a register that has both addresses, a write to the clear address stores old AND NOT data.
- R4: For a register with only a primary address (clear address configured as 0), a write stores the data unchanged.
- R5: A register of width W with field width F has W/F fields. Field k occupies bits [(W/F-1-k)*F +: F]. After an accepted write, each field whose bits differ between the old and new value produces one event for that field's source number. The event has evt_enable=1 if the new field is nonzero and evt_enable=0 if it is zero. Unchanged fields produce no event.
- R6: Events start in the cycle after the accepted write and appear one per cycle with evt_valid high, in ascending field index (field 0, the most significant, first).
- R7: A field whose configured source number is 0 never produces an event, even when its bits change. Its stored bits still update.
- R8: busy is high exactly while events remain to be sent. A write presented while busy is high is ignored: the stored register is left unchanged and no events are added.
- R9: With rd_en high, rdata returns the stored value of the addressed register (at either of its addresses). An address that matches no register reads 0, and a write to it changes nothing and produces no event.
- R10: After reset all registers read 0, busy is low and evt_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (rdata is combinational) |
| addr | input | 32 | Bus address |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data, 0 when nothing is addressed |
| busy | output | 1 | Events outstanding; writes are ignored |
| evt_valid | output | 1 | An event is presented this cycle |
| evt_id | output | ID_W | Source number of the event |
| evt_enable | output | 1 | 1 = enable, 0 = disable |

## Verification
The bench sweeps every data byte through each access mode of a three-register configuration: a one-bit-field mask register with both addresses, a four-bit priority register with only a primary address, and a two-bit priority register with both addresses. For each write it computes the expected value and the expected event list by shifting fields out arithmetically. A design that reversed the field order would send the events in the wrong order with the wrong source numbers. A design that dropped the unchanged-field filter would send extra events. A design that still signalled a field with source number 0 would add an event for it. Further targeted checks cover a write while busy (a design that accepted it would clear the register), the alias through bits 31:29 (a design comparing all 32 bits would miss the write), an address that hits nothing (it should read 0), and the reset state.

// File: rtl/irq_mask_bank_pkg.sv
package irq_mask_bank_pkg;

  typedef enum logic [1:0] {
    WM_NONE   = 2'd0,
    WM_DIRECT = 2'd1,
    WM_OR     = 2'd2,
    WM_ANDN   = 2'd3
  } wmode_e;

  localparam int unsigned ADDR_MATCH_W = 29;

  function automatic logic [ADDR_MATCH_W-1:0] low_addr(input logic [31:0] a);
    return a[ADDR_MATCH_W-1:0];
  endfunction

endpackage

// File: rtl/irq_mask_bank_decode.sv
module irq_mask_bank_decode
  import irq_mask_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned IDX_W    = 2,
  parameter logic [NUM_REGS-1:0][31:0] SET_ADDR = '0,
  parameter logic [NUM_REGS-1:0][31:0] CLR_ADDR = '0
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx,
  output wmode_e           mode
);

  logic [NUM_REGS-1:0] set_hit;
  logic [NUM_REGS-1:0] clr_hit;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_match
    assign set_hit[g] = (SET_ADDR[g] != '0) && (low_addr(addr) == low_addr(SET_ADDR[g]));
    assign clr_hit[g] = (SET_ADDR[g] != '0) && (CLR_ADDR[g] != '0) &&
                        (low_addr(addr) == low_addr(CLR_ADDR[g]));
  end

  always_comb begin
    hit  = 1'b0;
    idx  = '0;
    mode = WM_NONE;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (set_hit[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        mode = (CLR_ADDR[i] != '0) ? WM_OR : WM_DIRECT;
      end else if (clr_hit[i]) begin
        hit  = 1'b1;
        idx  = IDX_W'(i);
        mode = WM_ANDN;
      end
    end
  end

endmodule

// File: rtl/irq_mask_bank_update.sv
module irq_mask_bank_update
  import irq_mask_bank_pkg::*;
#(
  parameter int unsigned REG_W = 8,
  parameter int unsigned ID_W  = 6
) (
  input  logic [REG_W-1:0]           old_val,
  input  logic [REG_W-1:0]           wdata,
  input  wmode_e                     mode,
  input  logic [3:0]                 fld_w,
  input  logic [REG_W-1:0][ID_W-1:0] ids,
  output logic [REG_W-1:0]           new_val,
  output logic [REG_W-1:0]           chg,
  output logic [REG_W-1:0]           en
);

  function automatic logic [REG_W-1:0] slot_mask(input int fw, input int slot);
    logic [REG_W-1:0] m;
    m = '0;
    for (int b = 0; b < REG_W; b++) begin
      if (b >= slot * fw && b < slot * fw + fw) m[b] = 1'b1;
    end
    return m;
  endfunction

  always_comb begin
    case (mode)
      WM_OR:     new_val = old_val | wdata;
      WM_ANDN:   new_val = old_val & ~wdata;
      WM_DIRECT: new_val = wdata;
      default:   new_val = old_val;
    endcase
  end

  int               n_fields;
  logic [REG_W-1:0] fmask;

  always_comb begin
    n_fields = (fld_w == 4'd0) ? 0 : int'(REG_W) / int'(fld_w);
    chg      = '0;
    en       = '0;
    fmask    = '0;
    for (int k = 0; k < REG_W; k++) begin
      if (k < n_fields) begin
        fmask  = slot_mask(int'(fld_w), n_fields - 1 - k);
        chg[k] = (((old_val ^ new_val) & fmask) != '0) && (ids[k] != '0);
        en[k]  = ((new_val & fmask) != '0);
      end
    end
  end

endmodule

// File: rtl/irq_mask_bank_evtseq.sv
module irq_mask_bank_evtseq #(
  parameter int unsigned FIELDS = 8,
  parameter int unsigned ID_W   = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [FIELDS-1:0]           chg,
  input  logic [FIELDS-1:0]           en,
  input  logic [FIELDS-1:0][ID_W-1:0] ids,
  output logic                        evt_valid,
  output logic [ID_W-1:0]             evt_id,
  output logic                        evt_enable,
  output logic                        busy,
  output logic [FIELDS-1:0]           pend
);

  localparam int unsigned SEL_W = (FIELDS > 1) ? $clog2(FIELDS) : 1;

  logic [FIELDS-1:0]           en_q;
  logic [FIELDS-1:0][ID_W-1:0] ids_q;
  logic [SEL_W-1:0]            sel;

  always_comb begin
    sel = '0;
    for (int k = FIELDS - 1; k >= 0; k--) begin
      if (pend[k]) sel = SEL_W'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      en_q  <= '0;
      ids_q <= '0;
    end else if (load) begin
      pend  <= chg;
      en_q  <= en;
      ids_q <= ids;
    end else if (pend != '0) begin
      pend[sel] <= 1'b0;
    end
  end

  assign evt_valid  = (pend != '0);
  assign busy       = (pend != '0);
  assign evt_id     = ids_q[sel];
  assign evt_enable = en_q[sel];

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irq_mask_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ID_W     = 6,
  parameter logic [NUM_REGS-1:0][31:0] SET_ADDR = {32'h0000_1020, 32'h0000_1010, 32'h0000_1000},
  parameter logic [NUM_REGS-1:0][31:0] CLR_ADDR = {32'h0000_1024, 32'h0000_0000, 32'h0000_1004},
  parameter logic [NUM_REGS-1:0][3:0]  FLD_W    = {4'd2, 4'd4, 4'd1},
  parameter logic [NUM_REGS-1:0][REG_W-1:0][ID_W-1:0] SRC_ID = {
    6'd0, 6'd0, 6'd0, 6'd0, 6'd14, 6'd13, 6'd12, 6'd11,
    6'd0, 6'd0, 6'd0, 6'd0, 6'd0,  6'd0,  6'd10, 6'd9,
    6'd8, 6'd7, 6'd6, 6'd5, 6'd0,  6'd3,  6'd2,  6'd1
  }
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [31:0]      addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             busy,
  output logic             evt_valid,
  output logic [ID_W-1:0]  evt_id,
  output logic             evt_enable
);

  localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [NUM_REGS-1:0][REG_W-1:0] regs;
  logic                           hit;
  logic [IDX_W-1:0]               idx;
  wmode_e                         wr_mode;
  logic                           wr_acc;
  logic [REG_W-1:0]               old_val;
  logic [REG_W-1:0]               new_val;
  logic [REG_W-1:0]               chg;
  logic [REG_W-1:0]               en;
  logic [REG_W-1:0]               pend;

  irq_mask_bank_decode #(
    .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_decode (
    .addr(addr), .hit(hit), .idx(idx), .mode(wr_mode)
  );

  assign old_val = regs[idx];
  assign wr_acc  = wr_en && !busy && hit;

  irq_mask_bank_update #(.REG_W(REG_W), .ID_W(ID_W)) u_update (
    .old_val(old_val), .wdata(wdata), .mode(wr_mode), .fld_w(FLD_W[idx]),
    .ids(SRC_ID[idx]), .new_val(new_val), .chg(chg), .en(en)
  );

  irq_mask_bank_evtseq #(.FIELDS(REG_W), .ID_W(ID_W)) u_evtseq (
    .clk(clk), .rst_n(rst_n), .load(wr_acc), .chg(chg), .en(en), .ids(SRC_ID[idx]),
    .evt_valid(evt_valid), .evt_id(evt_id), .evt_enable(evt_enable),
    .busy(busy), .pend(pend)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (wr_acc) begin
      regs[idx] <= new_val;
    end
  end

  assign rdata = (rd_en && hit) ? old_val : '0;

endmodule

// File: rtl/irq_mask_bank_chk.sv
module irq_mask_bank_chk
  import irq_mask_bank_pkg::*;
#(
  parameter int unsigned NUM_REGS = 3,
  parameter int unsigned REG_W    = 8,
  parameter int unsigned ID_W     = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic                           hit,
  input logic                           wr_acc,
  input wmode_e                         wr_mode,
  input logic [REG_W-1:0]               wdata,
  input logic [REG_W-1:0]               old_val,
  input logic [REG_W-1:0]               new_val,
  input logic [REG_W-1:0]               rdata,
  input logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input logic [REG_W-1:0]               pend,
  input logic                           busy,
  input logic                           evt_valid,
  input logic [ID_W-1:0]                evt_id
);

  p_or_keeps_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_mode == WM_OR) |->
      ((new_val & old_val) == old_val) && ((new_val & wdata) == wdata));

  p_andn_removes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_mode == WM_ANDN) |->
      ((new_val & wdata) == '0) && ((new_val & ~old_val) == '0));

  p_direct_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && wr_mode == WM_DIRECT) |=> (regs == $past(regs)) || (regs != $past(regs)) && ($past(new_val) == $past(wdata)));

  p_one_per_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> ($countones(pend) + 1 == $countones($past(pend))));

  p_no_zero_id_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_id != '0));

  p_stall_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (regs == $past(regs)));

  p_miss_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |-> (rdata == '0));

  p_miss_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !hit) |=> (regs == $past(regs)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !evt_valid);

endmodule

bind irq_mask_bank irq_mask_bank_chk #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .ID_W(ID_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .hit(hit),
  .wr_acc(wr_acc), .wr_mode(wr_mode), .wdata(wdata), .old_val(old_val),
  .new_val(new_val), .rdata(rdata), .regs(regs), .pend(pend), .busy(busy),
  .evt_valid(evt_valid), .evt_id(evt_id)
);

// File: tb/test_irq_mask_bank.sv
`timescale 1ns/1ps
module test_irq_mask_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        busy;
  logic        evt_valid;
  logic [5:0]  evt_id;
  logic        evt_enable;

  always #4 clk = ~clk;

  irq_mask_bank i_irq_mask_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .evt_valid(evt_valid),
    .evt_id(evt_id), .evt_enable(evt_enable)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int model [3];
  int got_id [16];
  int got_en [16];
  int n_got;
  int exp_id [16];
  int exp_en [16];
  int n_exp;

  function automatic int fw_of(int r);
    return (r == 0) ? 1 : (r == 1) ? 4 : 2;
  endfunction

  function automatic int id_of(int r, int k);
    if (r == 0) return (k == 3) ? 0 : k + 1;
    if (r == 1) return (k < 2) ? 9 + k : 0;
    return (k < 4) ? 11 + k : 0;
  endfunction

  function automatic logic [31:0] set_of(int r);
    return 32'h1000 + 32'(r) * 32'h10;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = 8'(d);
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output int v);
    rd_en = 1'b1; addr = a;
    #1;
    v = int'(rdata);
    rd_en = 1'b0;
  endtask

  task automatic collect(input int start);
    n_got = start;
    while (evt_valid && n_got < 16) begin
      got_id[n_got] = int'(evt_id);
      got_en[n_got] = int'(evt_enable);
      n_got++;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic build_expect(input int r, input int oldv, input int newv);
    int fw, nf, sh, fo, fn;
    fw = fw_of(r);
    nf = 8 / fw;
    n_exp = 0;
    for (int k = 0; k < nf; k++) begin
      sh = (nf - 1 - k) * fw;
      fo = (oldv >> sh) % (1 << fw);
      fn = (newv >> sh) % (1 << fw);
      if (fo != fn && id_of(r, k) != 0) begin
        exp_id[n_exp] = id_of(r, k);
        exp_en[n_exp] = (fn != 0) ? 1 : 0;
        n_exp++;
      end
    end
  endtask

  task automatic compare_events(input string req);
    bit ok;
    ok = (n_got == n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++)
      if (got_id[i] != exp_id[i] || got_en[i] != exp_en[i]) ok = 1'b0;
    check(ok, req, "event list (count shown)", n_got, n_exp);
  endtask

  // side: 0 = primary address, 1 = clear address
  task automatic op(input int r, input int side, input int d, input logic [31:0] hi);
    int oldv, newv, rb;
    string req;
    oldv = model[r];
    if (r == 1) begin newv = d & 255; req = "R4"; end
    else if (side == 0) begin newv = (oldv | d) & 255; req = "R2"; end
    else begin newv = oldv & ~d & 255; req = "R3"; end
    bus_write(hi | (set_of(r) + (side != 0 ? 32'h4 : 32'h0)), d);
    collect(0);
    build_expect(r, oldv, newv);
    compare_events("R5/R6/R7 events");
    model[r] = newv;
    bus_read(set_of(r), rb);
    check(rb == newv, req, "stored value", rb, newv);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v;
    for (int r = 0; r < 3; r++) model[r] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    check(busy == 1'b0, "R10", "busy after reset", int'(busy), 0);
    check(evt_valid == 1'b0, "R10", "evt_valid after reset", int'(evt_valid), 0);
    for (int r = 0; r < 3; r++) begin
      bus_read(set_of(r), v);
      check(v == 0, "R10", "register after reset", v, 0);
    end

    // R7: field 3 of register 0 has source 0
    op(0, 0, 8'h10, 32'h0);
    check(n_got == 0, "R7", "events for id-0 field", n_got, 0);
    op(0, 1, 8'hFF, 32'h0);

    // R6 order: all mask fields on, field 0 first
    op(0, 0, 8'hFF, 32'h0);
    check(n_got > 0 && got_id[0] == 1 && got_id[n_got-1] == 8, "R6", "first/last event id",
          (n_got > 0) ? got_id[0] : -1, 1);
    op(0, 1, 8'hFF, 32'h0);

    // R1: alias through bits 31:29
    op(0, 0, 8'h81, 32'hE000_0000);
    check(model[0] == 8'h81 && n_got == 2, "R1", "aliased write events", n_got, 2);
    bus_read(32'h0001_1000, v);
    check(v == 0, "R1", "non-alias read", v, 0);

    // R9: unmatched address
    bus_write(32'h0000_2000, 8'hFF);
    check(busy == 1'b0 && evt_valid == 1'b0, "R9", "unmatched write events", int'(evt_valid), 0);
    bus_read(32'h0000_2000, v);
    check(v == 0, "R9", "unmatched read", v, 0);
    bus_read(32'h0000_1004, v);
    check(v == model[0], "R9", "read at clear address", v, model[0]);

    // R8: write while busy is ignored
    op(0, 1, 8'hFF, 32'h0);
    @(negedge clk);
    wr_en = 1'b1; addr = 32'h1000; wdata = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    check(busy == 1'b1, "R8", "busy while events pending", int'(busy), 1);
    got_id[0] = int'(evt_id); got_en[0] = int'(evt_enable);
    wr_en = 1'b1; addr = 32'h1004; wdata = 8'hFF;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    collect(1);
    build_expect(0, 0, 8'hFF);
    compare_events("R8 events with stalled write");
    model[0] = 8'hFF;
    bus_read(32'h1000, v);
    check(v == 8'hFF, "R8", "register after stalled clear", v, 8'hFF);

    // sweeps over all data values
    for (int d = 0; d < 256; d++) begin
      op(0, 0, d, 32'h0);
      op(0, 1, (d * 7) & 255, 32'h0);
    end
    for (int d = 0; d < 256; d++) op(1, 0, (d * 37 + 11) & 255, 32'h0);
    for (int d = 0; d < 256; d++) begin
      op(2, 0, d, 32'h0);
      op(2, 1, (d * 13 + 5) & 255, 32'h0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule